// File: doc/BRIEF.md
# Serial Overhead Byte Insertion Port

This block lets external logic supply the three line-overhead bytes E1, F1 and E2 of an outbound STS-3 frame through a single serial data pin. The transmit framer tells the block where each frame begins with `frm_start`. The block then paces the external source. It drives a one-cycle request strobe (`bit_req`) for every bit it wants and a one-cycle frame marker (`frm_mark`) at the start of each collection window. It samples the serial pin on the falling edge of the overhead clock and assembles the 24 bits into three bytes.

The collected bytes are double-buffered. A complete set gathered during one frame is handed to the insertion side only when the next frame starts. The overhead inserter then reads a stable set for a whole frame. To do so it names the overhead slot it is filling on `ins_sel`, and takes the byte from `ins_byte` together with a valid flag on `ins_vld`. When the serial pin is tied low, every inserted byte is zero.

Top module: `oh_serial_insert`

## Requirements
- R1: After `frm_start` is sampled high, `bit_req` pulses high for one cycle exactly 24 times. The first pulse comes in the next cycle and successive pulses are `BIT_GAP` cycles apart.
- R2: `frm_mark` is high for exactly one clock cycle, the cycle right after `frm_start` was sampled high.
- R3: Bits are collected in the order E1, F1, E2, each most significant bit first. The first requested bit becomes E1 bit 7 and the last becomes E2 bit 0.
- R4: For a request high in cycle r, the external logic launches the bit on the rising edge that ends cycle r. The block takes the value present at the falling edge inside cycle r+1, and the pin level at the following rising edge has no effect.
- R5: `frm_mark` coincides with the first `bit_req` pulse of a window, one cycle before the first E1 bit is captured.
- R6: `ins_sel` encodes 0 = no overhead slot, 1 = E1, 2 = F1, 3 = E2. `ins_byte` carries the selected committed byte and is 0 when `ins_sel` is 0. `ins_vld` is high only when `ins_sel` is nonzero and at least one complete set has been committed.
- R7: A completed set becomes visible only at the next `frm_start`. Between two frame starts the values on the insertion side do not change.
- R8: With the serial pin held low, a completed window commits E1 = F1 = E2 = 8'h00 with `ins_vld` high.
- R9: A synchronous reset clears the request sequencing, both byte buffers, `bit_req`, `frm_mark` and `ins_vld`. After reset no request is issued until `frm_start`.
- R10: A `frm_start` before a window has completed restarts collection from E1 bit 7 and discards the partial bits. The set on the insertion side keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Overhead clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_start | input | 1 | One-cycle frame start pulse from the transmit framer |
| ser_din | input | 1 | Serial overhead data from external logic |
| ins_sel | input | 2 | Overhead slot being filled: 0 none, 1 E1, 2 F1, 3 E2 |
| bit_req | output | 1 | One-cycle request for the next serial bit |
| frm_mark | output | 1 | One-cycle marker at the start of each collection window |
| ins_byte | output | BYTE_W | Committed byte for the selected slot |
| ins_vld | output | 1 | Selected byte is valid |

## Verification
The bench builds the block with `BIT_GAP` = 4 and `BYTE_W` = 8. With these values a full 24-bit window takes about 96 cycles and fits inside the 110-cycle frames the bench drives. This leaves room for a second frame start in mid-window and for reads of the insertion side while the next set is still being gathered. The gap of four cycles also makes spacing errors in the request sequencer visible. In addition, the bench source turns the serial pin to the complemented value right after each falling edge. A capture taken on the wrong clock edge therefore corrupts the assembled bytes.

// File: rtl/oh_serial_insert.sv
module oh_serial_insert #(
  parameter int BIT_GAP = 4,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic              ser_din,
  input  logic [1:0]        ins_sel,
  output logic              bit_req,
  output logic              frm_mark,
  output logic [BYTE_W-1:0] ins_byte,
  output logic              ins_vld
);
  localparam int NB = 3 * BYTE_W;
  localparam int CW = $clog2(NB + 1);
  localparam int GW = $clog2(BIT_GAP + 1);

  logic          run;
  logic [GW-1:0] gap_cnt;
  logic [CW-1:0] req_cnt;
  logic [CW-1:0] cap_cnt;
  logic          neg_q, sync_q;
  logic          req_d1, req_d2;
  logic [NB-1:0] shreg, pend, act;
  logic          pend_ok, act_ok;
  logic [NB-1:0] shifted;

  assign shifted = {shreg[NB-2:0], sync_q};

  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= ser_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      gap_cnt  <= '0;
      req_cnt  <= '0;
      cap_cnt  <= '0;
      sync_q   <= 1'b0;
      req_d1   <= 1'b0;
      req_d2   <= 1'b0;
      shreg    <= '0;
      pend     <= '0;
      pend_ok  <= 1'b0;
      act      <= '0;
      act_ok   <= 1'b0;
      bit_req  <= 1'b0;
      frm_mark <= 1'b0;
    end else begin
      bit_req  <= 1'b0;
      frm_mark <= 1'b0;
      sync_q   <= neg_q;
      req_d1   <= bit_req;
      req_d2   <= req_d1;
      if (frm_start) begin
        frm_mark <= 1'b1;
        bit_req  <= 1'b1;
        run      <= 1'b1;
        gap_cnt  <= '0;
        req_cnt  <= CW'(1);
        cap_cnt  <= '0;
        req_d1   <= 1'b0;
        req_d2   <= 1'b0;
        if (pend_ok) begin
          act     <= pend;
          act_ok  <= 1'b1;
          pend_ok <= 1'b0;
        end
      end else begin
        if (run) begin
          if (gap_cnt == GW'(BIT_GAP - 1)) begin
            gap_cnt <= '0;
            if (req_cnt == CW'(NB)) begin
              run <= 1'b0;
            end else begin
              bit_req <= 1'b1;
              req_cnt <= req_cnt + CW'(1);
            end
          end else begin
            gap_cnt <= gap_cnt + GW'(1);
          end
        end
        if (req_d2) begin
          shreg <= shifted;
          if (cap_cnt == CW'(NB - 1)) begin
            cap_cnt <= '0;
            pend    <= shifted;
            pend_ok <= 1'b1;
          end else begin
            cap_cnt <= cap_cnt + CW'(1);
          end
        end
      end
    end
  end

  always_comb begin
    case (ins_sel)
      2'd1:    ins_byte = act[NB-1 -: BYTE_W];
      2'd2:    ins_byte = act[NB-1-BYTE_W -: BYTE_W];
      2'd3:    ins_byte = act[BYTE_W-1:0];
      default: ins_byte = '0;
    endcase
  end

  assign ins_vld = act_ok && (ins_sel != 2'd0);

  // R2: marker lasts one cycle unless a new frame start follows at once
  a_r2_mark_single: assert property (@(posedge clk) disable iff (rst)
    frm_mark |=> (!frm_mark || $past(frm_start)));

  // R5: marker coincides with the first request of a window
  a_r5_mark_with_req: assert property (@(posedge clk) disable iff (rst)
    frm_mark |-> bit_req);

  // R1: no more captures than bits in a window
  a_r1_cap_bound: assert property (@(posedge clk) disable iff (rst)
    req_d2 |-> (cap_cnt < CW'(NB)));

  generate
    if (BIT_GAP > 1) begin : g_gap
      // R1: requests are single-cycle pulses when spaced
      a_r1_req_spaced: assert property (@(posedge clk) disable iff (rst)
        (bit_req && !frm_start) |=> !bit_req);
    end
  endgenerate

  // R7: committed set only changes at a frame start
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !frm_start |=> ($stable(act) && $stable(act_ok)));

  // R6: valid only with a slot selected and a committed set
  a_r6_vld_sel: assert property (@(posedge clk) disable iff (rst)
    ins_vld |-> ((ins_sel != 2'd0) && act_ok));

  // R9: synchronous reset silences both strobes
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bit_req && !frm_mark && !ins_vld));
endmodule

// File: tb/oh_serial_insert_bench.sv
module oh_serial_insert_bench;
  localparam int CLK_P = 10;
  localparam int GAP   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_start = 1'b0;
  logic       ser_din = 1'b0;
  logic [1:0] ins_sel = 2'd0;
  logic       bit_req, frm_mark, ins_vld;
  logic [7:0] ins_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] src = '0;
  bit          tie_low = 1'b0;
  int          idx = 0;

  int mark_n = 0, req_n = 0, gap_bad = 0, mark_bad = 0;
  int since = 0;
  logic st_prev = 1'b0;

  oh_serial_insert #(.BIT_GAP(GAP), .BYTE_W(8)) u_oh_serial_insert (
    .clk(clk), .rst(rst), .frm_start(frm_start), .ser_din(ser_din),
    .ins_sel(ins_sel), .bit_req(bit_req), .frm_mark(frm_mark),
    .ins_byte(ins_byte), .ins_vld(ins_vld));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial source: launch after the rising edge, poison after the falling edge
  initial begin
    logic rs;
    forever begin
      @(negedge clk);
      rs = bit_req;
      if (frm_mark) idx = 0;
      #1;
      if (tie_low) ser_din = 1'b0;
      else         ser_din = ~ser_din;
      @(posedge clk);
      #1;
      if (tie_low)  ser_din = 1'b0;
      else if (rs) begin
        ser_din = (idx < 24) ? src[23-idx] : 1'b0;
        idx++;
      end
    end
  end

  // strobe monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (frm_mark) begin
        mark_n++;
        if (!st_prev || !bit_req) mark_bad++;
        req_n = 0;
      end
      if (bit_req) begin
        if (req_n > 0 && since != GAP) gap_bad++;
        req_n++;
        since = 0;
      end
      since++;
      st_prev = frm_start;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    @(posedge clk);
    #1;
    mark_n = 0; req_n = 0; gap_bad = 0; mark_bad = 0;
    frm_start = 1'b1;
    @(posedge clk);
    #1;
    frm_start = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] b, output logic v);
    @(posedge clk);
    #1;
    ins_sel = s;
    @(negedge clk);
    b = ins_byte;
    v = ins_vld;
  endtask

  task automatic chk_set(input logic [23:0] exp, input string req);
    logic [7:0] b;
    logic v;
    for (int s = 1; s <= 3; s++) begin
      rd(2'(s), b, v);
      chk(b == exp[23-8*(s-1) -: 8], req, b, exp[23-8*(s-1) -: 8]);
      chk(v == 1'b1, req, v, 1);
    end
  endtask

  task automatic t_reset();
    logic [7:0] b;
    logic v;
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(5);
    @(negedge clk);
    chk(bit_req == 1'b0, "R9 bit_req after reset", bit_req, 0);
    chk(frm_mark == 1'b0, "R9 frm_mark after reset", frm_mark, 0);
    rd(2'd1, b, v);
    chk(v == 1'b0, "R9 ins_vld after reset", v, 0);
    chk(b == 8'h00, "R9 ins_byte after reset", b, 0);
    chk(req_n == 0, "R9 no request without frame start", req_n, 0);
  endtask

  task automatic t_strobes();
    logic [7:0] b;
    logic v;
    src = 24'hA53C81;
    pulse_start();
    cyc(108);
    chk(req_n == 24, "R1 request count", req_n, 24);
    chk(gap_bad == 0, "R1 request spacing", gap_bad, 0);
    chk(mark_n == 1, "R2 marker count", mark_n, 1);
    chk(mark_bad == 0, "R2 R5 marker placement", mark_bad, 0);
    rd(2'd1, b, v);
    chk(v == 1'b0, "R7 set not visible before next start", v, 0);
  endtask

  task automatic t_handoff();
    logic [7:0] b;
    logic v;
    src = 24'h1EC76B;
    pulse_start();
    chk_set(24'hA53C81, "R3 R4 R6 byte order and capture edge");
    rd(2'd0, b, v);
    chk(v == 1'b0, "R6 no slot selected vld", v, 0);
    chk(b == 8'h00, "R6 no slot selected byte", b, 0);
    cyc(50);
    rd(2'd3, b, v);
    chk(b == 8'h81, "R7 held during next window", b, 8'h81);
    cyc(48);
    pulse_start();
    chk_set(24'h1EC76B, "R7 second set committed");
    cyc(105);
  endtask

  task automatic t_tielow();
    tie_low = 1'b1;
    pulse_start();
    cyc(108);
    pulse_start();
    chk_set(24'h000000, "R8 tied low gives zeros");
    tie_low = 1'b0;
    cyc(105);
  endtask

  task automatic t_abort();
    src = 24'h5AF00F;
    pulse_start();
    cyc(108);
    src = 24'h3396CC;
    pulse_start();
    chk_set(24'h5AF00F, "R10 set before abort");
    cyc(30);
    pulse_start();
    chk_set(24'h5AF00F, "R10 partial window discarded");
    cyc(100);
    chk(req_n == 24, "R10 restarted window request count", req_n, 24);
    pulse_start();
    chk_set(24'h3396CC, "R10 restarted window from E1 bit 7");
  endtask

  task automatic t_midreset();
    logic [7:0] b;
    logic v;
    cyc(20);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    req_n = 0;
    cyc(40);
    @(negedge clk);
    chk(req_n == 0, "R9 requests stop after reset", req_n, 0);
    rd(2'd2, b, v);
    chk(v == 1'b0, "R9 vld cleared by reset", v, 0);
    chk(b == 8'h00, "R9 buffers cleared by reset", b, 0);
  endtask

  initial begin
    t_reset();
    t_strobes();
    t_handoff();
    t_tielow();
    t_abort();
    t_midreset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule